// File: doc/BRIEF.md
# Fractional Baud Enable Generator

This block turns a fast reference clock into the two timing strobes a UART needs: an oversampling strobe that fires on average sixteen times per bit, and a bit-rate strobe that fires once per bit. Both strobes are single reference-clock cycles wide. Software supplies the wanted divisor as reference clock divided by sixteen times the baud rate. The divisor is split into a 16-bit whole part and a 6-bit fraction counted in sixty-fourths. The fraction field is obtained by rounding: take the fractional part, multiply by 64, add one half and truncate.

The whole part sets the base spacing of the oversampling strobe. The fraction is summed into a 6-bit accumulator once per strobe. Each time that sum wraps, the following strobe period is stretched by one reference clock. Over any 64 consecutive periods the average spacing is therefore exactly the whole part plus the fraction over 64. This lets an arbitrary reference clock reach the standard baud rates, at the cost of up to one clock of jitter per period. A smaller divisor gives a shorter bit period.

All pins are plain control and status signals. There is no data stream and no handshake. A change on either divisor field restarts the block. An enable input parks it.

Top module: `baud_tick_gen`

## Requirements
- R1: While reset is asserted, and in the first sampled cycle after it, `tick16` and `tick1` are 0.
- R2: With a nonzero whole part D, the spacing between consecutive `tick16` pulses is always D or D+1 reference cycles. The spacing is D+1 exactly when the fraction accumulator (starting at 0, with the fraction F added on every pulse, modulo 64) wrapped on the pulse that opened the period.
- R3: With F = 0, every `tick16` spacing equals D. This includes D = 1, where `tick16` is high in every cycle.
- R4: With F nonzero, the cycles from the 1st to the 65th `tick16` after a restart total exactly 64·D + F.
- R5: `tick1` is high only together with `tick16`, and exactly on the 16th, 32nd, 48th and so on `tick16` pulse counted from a restart.
- R6: A cycle in which `div_int` or `div_frac` differs from its value in the previous cycle carries no `tick16`. All counters and the accumulator restart, and the first `tick16` comes D cycles after that cycle.
- R7: While `div_int` is 0, no `tick16` or `tick1` is produced.
- R8: While `run` is 0, no strobe is produced and all counters are held at 0. After `run` rises, the first `tick16` falls in the D-th cycle with `run` high.

Top module port list follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low reset, synchronous to `clk` |
| run | input | 1 | Enable; low parks and clears all counters |
| div_int | input | 16 | Whole part of the divisor |
| div_frac | input | 6 | Fraction of the divisor in sixty-fourths |
| tick16 | output | 1 | Oversampling strobe, one cycle wide |
| tick1 | output | 1 | Bit-rate strobe, one cycle wide |

## Verification
Two events meet in one cycle here. The first is a divisor change landing in a cycle where a `tick16` is due. The bench provokes this by moving from D = 1, F = 0, where every cycle carries a pulse, to a new divisor: the change cycle must be silent and the first pulse must come D cycles later. The second is the 16th oversampling pulse, which must carry `tick1` alongside it. Every pulse is compared against a pulse count kept in the bench. Random divisors check each spacing against an accumulator model and the 64-period total against 64·D + F.

// File: rtl/baud_pkg.sv
package baud_pkg;
  localparam int BAUD_INT_W     = 16;
  localparam int BAUD_FRAC_W    = 6;
  localparam int BAUD_OVERSAMPLE = 16;
endpackage

// File: rtl/baud_frac_acc.sv
module baud_frac_acc #(
  parameter int FRAC_W = baud_pkg::BAUD_FRAC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              step,
  input  logic [FRAC_W-1:0] frac,
  output logic              stretch
);
  logic [FRAC_W-1:0] acc_q;
  logic [FRAC_W:0]   sum;

  assign sum = {1'b0, acc_q} + {1'b0, frac};

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      acc_q   <= '0;
      stretch <= 1'b0;
    end else if (step) begin
      acc_q   <= sum[FRAC_W-1:0];
      stretch <= sum[FRAC_W];
    end
  end

  // R6
  acc_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (acc_q == '0 && !stretch));
endmodule

// File: rtl/baud_period_cnt.sv
module baud_period_cnt #(
  parameter int INT_W = baud_pkg::BAUD_INT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic [INT_W-1:0] div_int,
  input  logic             stretch,
  output logic             due
);
  localparam int LW = INT_W + 1;

  logic [INT_W-1:0] cnt_q;
  logic [LW-1:0]    last_idx;

  assign last_idx = {1'b0, div_int} - LW'(1) + LW'(stretch);
  assign due      = (div_int != '0) && ({1'b0, cnt_q} == last_idx);

  always_ff @(posedge clk) begin
    if (!rst_n || clear || due) cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end

  // R2
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && div_int != '0) |-> ({1'b0, cnt_q} <= last_idx));

  // R8
  cnt_parked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt_q == '0));
endmodule

// File: rtl/baud_sub_div.sv
module baud_sub_div #(
  parameter int RATIO = baud_pkg::BAUD_OVERSAMPLE
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic step,
  output logic pulse
);
  localparam int CW = (RATIO > 2) ? $clog2(RATIO) : 1;

  logic [CW-1:0] cnt_q;
  logic          at_end;

  assign at_end = (cnt_q == CW'(RATIO - 1));
  assign pulse  = step && at_end;

  always_ff @(posedge clk) begin
    if (!rst_n || clear)  cnt_q <= '0;
    else if (step)        cnt_q <= at_end ? '0 : cnt_q + 1'b1;
  end

  // R5
  sub_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse && !clear) |=> (cnt_q == '0));
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen #(
  parameter int INT_W      = baud_pkg::BAUD_INT_W,
  parameter int FRAC_W     = baud_pkg::BAUD_FRAC_W,
  parameter int OVERSAMPLE = baud_pkg::BAUD_OVERSAMPLE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [INT_W-1:0]  div_int,
  input  logic [FRAC_W-1:0] div_frac,
  output logic              tick16,
  output logic              tick1
);
  logic [INT_W-1:0]  int_seen_q;
  logic [FRAC_W-1:0] frac_seen_q;
  logic              reload;
  logic              active;
  logic              clear;
  logic              due;
  logic              stretch;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      int_seen_q  <= '0;
      frac_seen_q <= '0;
    end else begin
      int_seen_q  <= div_int;
      frac_seen_q <= div_frac;
    end
  end

  assign reload = (div_int != int_seen_q) || (div_frac != frac_seen_q);
  assign active = run && (div_int != '0);
  assign clear  = !active || reload;
  assign tick16 = due && !clear;

  baud_period_cnt #(.INT_W(INT_W)) u_period (
    .clk(clk), .rst_n(rst_n), .clear(clear),
    .div_int(div_int), .stretch(stretch), .due(due)
  );

  baud_frac_acc #(.FRAC_W(FRAC_W)) u_frac (
    .clk(clk), .rst_n(rst_n), .clear(clear),
    .step(tick16), .frac(div_frac), .stretch(stretch)
  );

  baud_sub_div #(.RATIO(OVERSAMPLE)) u_sub (
    .clk(clk), .rst_n(rst_n), .clear(clear),
    .step(tick16), .pulse(tick1)
  );

  // R7
  zero_div_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (div_int == '0) |-> (!tick16 && !tick1));

  // R8
  parked_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (!tick16 && !tick1));

  // R5
  bit_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick1 |-> tick16);

  // R6
  change_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reload |-> !tick16);
endmodule

// File: tb/baud_tick_gen_test.sv
module baud_tick_gen_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run = 1'b1;
  logic [15:0] div_int = '0;
  logic [5:0]  div_frac = '0;
  logic        tick16, tick1;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;
  int cur_d = 0;
  int cur_f = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  baud_tick_gen uut (
    .clk(clk), .rst_n(rst_n), .run(run),
    .div_int(div_int), .div_frac(div_frac),
    .tick16(tick16), .tick1(tick1)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d (D=%0d F=%0d)", req, act, exp, cur_d, cur_f);
    end
  endtask

  function automatic int next_gap(input int d, input int f, inout int acc);
    acc = acc + f;
    if (acc >= 64) begin
      acc = acc - 64;
      return d + 1;
    end
    return d;
  endfunction

  task automatic set_div(input int d, input int f);
    @(posedge clk); #1;
    div_int = 16'(d); div_frac = 6'(f);
    cur_d = d; cur_f = f;
  endtask

  // Change divisor, then follow nper pulses against the model.
  task automatic run_periods(input int d, input int f, input int nper);
    int acc = 0;
    int g = 0;
    int exp_gap = d;
    int ticks = 0;
    int span = 0;
    bit first = 1'b1;
    set_div(d, f);
    @(negedge clk);
    chk(tick16 == 1'b0, "R6 change cycle silent", int'(tick16), 0);
    while (ticks < nper) begin
      @(negedge clk);
      g++;
      if (ticks >= 1) span++;
      if (tick16) begin
        ticks++;
        if (first) chk(g == exp_gap, "R6 first tick after change", g, exp_gap);
        else if (f == 0) chk(g == exp_gap, "R3 integer spacing", g, exp_gap);
        else chk(g == exp_gap, "R2 fractional spacing", g, exp_gap);
        chk(tick1 == ((ticks % 16) == 0), "R5 bit strobe position", int'(tick1), int'((ticks % 16) == 0));
        if (ticks == 65 && f != 0)
          chk(span == 64*d + f, "R4 64-period total", span, 64*d + f);
        first = 1'b0;
        exp_gap = next_gap(d, f, acc);
        g = 0;
      end else begin
        if (tick1) chk(1'b0, "R5 bit strobe without tick16", 1, 0);
        if (g > d + 1) begin
          chk(1'b0, "R2 spacing overrun", g, exp_gap);
          ticks = nper;
        end
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int d, f;
    void'($urandom(32'h1f2e3d4c));
    // R1 reset state
    div_int = 16'd4; div_frac = 6'd0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(tick16 == 1'b0 && tick1 == 1'b0, "R1 reset outputs", int'(tick16) + int'(tick1), 0);
    end
    @(posedge clk); #1; rst_n = 1'b1; div_int = 16'd0;
    @(negedge clk);
    chk(tick16 == 1'b0 && tick1 == 1'b0, "R1 first cycle after reset", int'(tick16) + int'(tick1), 0);

    // Directed corners
    run_periods(1, 0, 40);   // R3 tick every cycle
    run_periods(3, 0, 20);   // R6 change lands on a due tick
    run_periods(1, 63, 70);  // spacing 1 or 2
    run_periods(2, 32, 70);
    run_periods(300, 1, 66);

    // R7 zero whole part
    set_div(0, 5);
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      chk(tick16 == 1'b0 && tick1 == 1'b0, "R7 zero divisor silent", int'(tick16) + int'(tick1), 0);
    end

    // R8 run low parks, rise restarts
    set_div(5, 0);
    @(posedge clk); #1; run = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      chk(tick16 == 1'b0 && tick1 == 1'b0, "R8 parked silent", int'(tick16) + int'(tick1), 0);
    end
    @(posedge clk); #1; run = 1'b1;
    for (int k = 1; k <= 5; k++) begin
      @(negedge clk);
      chk(tick16 == (k == 5), "R8 first tick after run rises", int'(tick16), int'(k == 5));
    end

    // Random divisors
    for (int n = 0; n < 14; n++) begin
      d = 1 + int'($urandom_range(59));
      f = int'($urandom_range(63));
      if (d == cur_d && f == cur_f) f = (f + 1) % 64;
      run_periods(d, f, 66);
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule